// File: doc/BRIEF.md
# Iterative integer divider

A multi-cycle unit that divides two `W`-bit integers and returns either the quotient or the remainder, in signed or unsigned form. A one-cycle `start` pulse hands it a 2-bit operation code and two operands. The unit raises `busy` and runs a shift-and-subtract loop that yields one quotient bit per cycle. When the result is ready, `done` pulses for one cycle.

The loop always works on unsigned magnitudes. Signed operands are made positive in a preparation cycle, and the signs are restored in a final fix-up cycle. Each step shifts the partial remainder left by one bit and forms a trial difference against the divisor. If the difference would be negative it is dropped, and the shifted value is kept as it is, so no add-back step is needed.

Two cases never trap and finish in the preparation cycle with a fixed answer: a zero divisor, and the one signed quotient that cannot be represented.

Top module: `int_divider`

## Requirements
- R1: Op code 2'b01 returns the unsigned quotient floor(a/b) for a nonzero divisor.
- R2: Op code 2'b11 returns the unsigned remainder a mod b for a nonzero divisor.
- R3: Op code 2'b00 returns the two's-complement quotient, rounded toward zero. Its magnitude is |a|/|b|, and it is negative exactly when the operand signs differ and the magnitude is nonzero.
- R4: Op code 2'b10 returns the signed remainder a - b*q, using q from R3. A nonzero remainder has the sign of the dividend.
- R5: For any op code, a zero divisor yields a remainder equal to the dividend and a quotient with all W bits set.
- R6: For a signed op, a dividend of only the top bit set divided by all ones (-1) yields that same dividend as quotient and 0 as remainder.
- R7: `busy` rises in the cycle after an accepted `start` and stays high for W+2 cycles on a normal division, or for 1 cycle in the cases of R5 and R6. `done` is high in the first cycle with `busy` low.
- R8: A `start` received while `busy` is high is ignored: the running operation completes with its original operands.
- R9: `done` lasts exactly one cycle. `result` holds its value from the `done` cycle until a later operation completes.
- R10: While reset is active, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation; taken only while `busy` is low |
| op | input | 2 | Bit 1: remainder (1) or quotient (0); bit 0: unsigned (1) or signed (0) |
| opa | input | W | Dividend |
| opb | input | W | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Quotient or remainder |

## Verification
The bench builds two copies of the divider. The first uses W=5, which makes it possible to sweep every op code against every dividend and divisor pair: 4096 operations covering all zero divisors, the signed overflow point and every sign combination. The second uses the default W=32 and exercises the corner operands 0, 1, -1, the minimum negative value and the maximum positive value, plus a set of random operands. The latency of each operation is measured, busy-time start pulses are injected with altered operands, and the result is checked to hold after completion.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
  typedef enum logic [1:0] {
    OP_SQUO = 2'b00,
    OP_UQUO = 2'b01,
    OP_SREM = 2'b10,
    OP_UREM = 2'b11
  } idiv_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PREP = 2'b01,
    ST_ITER = 2'b10,
    ST_FIX  = 2'b11
  } idiv_state_e;
endpackage

// File: rtl/idiv_operand_prep.sv
module idiv_operand_prep #(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] mag_dvd,
  output logic [W-1:0] mag_dvs,
  output logic         neg_quo,
  output logic         neg_rem,
  output logic         zero_dvs,
  output logic         sgn_ovf
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic is_signed;
  logic sgn_a;
  logic sgn_b;

  always_comb begin
    is_signed = ~op[0];
    sgn_a     = is_signed & dvd[W-1];
    sgn_b     = is_signed & dvs[W-1];
    mag_dvd   = sgn_a ? (~dvd + 1'b1) : dvd;
    mag_dvs   = sgn_b ? (~dvs + 1'b1) : dvs;
    neg_quo   = sgn_a ^ sgn_b;
    neg_rem   = sgn_a;
    zero_dvs  = (dvs == '0);
    sgn_ovf   = is_signed & (dvd == MIN_NEG) & (dvs == '1);
  end
endmodule

// File: rtl/idiv_iter_core.sv
module idiv_iter_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W-1:0] part_q, part_d;
  logic [W-1:0] quo_q, quo_d;
  logic [W-1:0] dvs_q, dvs_d;
  logic [W:0]   shifted;
  logic [W:0]   trial;
  logic         keep;

  always_comb begin
    shifted = {part_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
    keep    = ~trial[W];
    part_d  = part_q;
    quo_d   = quo_q;
    dvs_d   = dvs_q;
    if (load) begin
      part_d = '0;
      quo_d  = dvd;
      dvs_d  = dvs;
    end else if (step) begin
      // a negative trial is simply not written back
      part_d = keep ? trial[W-1:0] : shifted[W-1:0];
      quo_d  = {quo_q[W-2:0], keep};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else if (load || step) begin
      part_q <= part_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
    end
  end

  assign quo = quo_q;
  assign rem = part_q;
endmodule

// File: rtl/idiv_sign_fix.sv
module idiv_sign_fix #(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] quo,
  input  logic [W-1:0] rem,
  input  logic         neg_quo,
  input  logic         neg_rem,
  output logic [W-1:0] res
);
  always_comb begin
    if (op[1]) res = neg_rem ? (~rem + 1'b1) : rem;
    else       res = neg_quo ? (~quo + 1'b1) : quo;
  end
endmodule

// File: rtl/int_divider.sv
module int_divider
  import idiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  idiv_state_e  state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]   op_q;
  logic [W-1:0] a_q, b_q;
  logic         done_q, done_d;
  logic [W-1:0] result_q, result_d;
  logic         lat_en, core_load, core_step, cnt_en;

  logic [W-1:0] mag_a, mag_b, core_quo, core_rem, fixed_res, special_res;
  logic         neg_quo, neg_rem, zero_dvs, sgn_ovf;

  idiv_operand_prep #(.W(W)) i_prep (
    .op(op_q), .dvd(a_q), .dvs(b_q),
    .mag_dvd(mag_a), .mag_dvs(mag_b),
    .neg_quo(neg_quo), .neg_rem(neg_rem),
    .zero_dvs(zero_dvs), .sgn_ovf(sgn_ovf)
  );

  idiv_iter_core #(.W(W)) i_core (
    .clk(clk), .rst_n(rst_sync_n),
    .load(core_load), .step(core_step),
    .dvd(mag_a), .dvs(mag_b),
    .quo(core_quo), .rem(core_rem)
  );

  idiv_sign_fix #(.W(W)) i_fix (
    .op(op_q), .quo(core_quo), .rem(core_rem),
    .neg_quo(neg_quo), .neg_rem(neg_rem),
    .res(fixed_res)
  );

  always_comb begin
    if (zero_dvs) special_res = op_q[1] ? a_q : '1;
    else          special_res = op_q[1] ? '0 : a_q;
  end

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    done_d    = 1'b0;
    result_d  = result_q;
    lat_en    = 1'b0;
    core_load = 1'b0;
    core_step = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          lat_en  = 1'b1;
          state_d = ST_PREP;
        end
      end
      ST_PREP: begin
        if (zero_dvs || sgn_ovf) begin
          result_d = special_res;
          done_d   = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          core_load = 1'b1;
          cnt_d     = '0;
          cnt_en    = 1'b1;
          state_d   = ST_ITER;
        end
      end
      ST_ITER: begin
        core_step = 1'b1;
        cnt_d     = cnt_q + 1'b1;
        cnt_en    = 1'b1;
        if (cnt_q == LAST) state_d = ST_FIX;
      end
      ST_FIX: begin
        result_d = fixed_res;
        done_d   = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      result_q <= result_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else if (lat_en) begin
      op_q <= op;
      a_q  <= opa;
      b_q  <= opb;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign result = result_q;
endmodule

// File: rtl/int_divider_chk.sv
module int_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result,
  input logic [1:0]   op_q,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q
);
  localparam int NW = $clog2(W + 4) + 1;
  localparam logic [NW-1:0] FULL = NW'(W + 2);
  localparam logic [NW-1:0] ONE  = NW'(1);
  localparam logic [W-1:0]  MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [NW-1:0] busy_cnt;
  logic          special;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  assign special = (b_q == '0) || (!op_q[0] && a_q == MIN_NEG && b_q == '1);

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_LAT_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && special) |-> (busy_cnt == ONE)); // R7
  AST_LAT_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !special) |-> (busy_cnt == FULL)); // R7
  AST_OPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(a_q) && $stable(b_q) && $stable(op_q))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R9
  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && b_q == '0) |-> (result == (op_q[1] ? a_q : '1))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_q[0] && a_q == MIN_NEG && b_q == '1) |-> (result == (op_q[1] ? '0 : MIN_NEG))); // R6
endmodule

bind int_divider int_divider_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .result(result), .op_q(op_q), .a_q(a_q), .b_q(b_q)
);

// File: tb/test_int_divider.sv
`timescale 1ns/1ps
module test_int_divider;
  localparam int WN = 5;
  localparam int WW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b0, start_w = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = '0, b = '0;
  logic busy_n, done_n, busy_w, done_w;
  logic [WN-1:0] result_n;
  logic [WW-1:0] result_w;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  int_divider #(.W(WN)) i_int_divider (
    .clk(clk), .rst_n(rst_n), .start(start_n), .op(op),
    .opa(a[WN-1:0]), .opb(b[WN-1:0]),
    .busy(busy_n), .done(done_n), .result(result_n)
  );

  int_divider #(.W(WW)) i_int_divider_w32 (
    .clk(clk), .rst_n(rst_n), .start(start_w), .op(op),
    .opa(a), .opb(b),
    .busy(busy_w), .done(done_w), .result(result_w)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] o, input logic [31:0] x,
                                        input logic [31:0] y, input int w, output bit spec);
    longint m, ua, ub, sa, sb, q, r, half;
    logic [63:0] v;
    m    = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    ua = longint'(x) & m;
    ub = longint'(y) & m;
    sa = (ua >= half) ? ua - (m + 1) : ua;
    sb = (ub >= half) ? ub - (m + 1) : ub;
    spec = 1'b0;
    if (ub == 0) begin
      q = -1; r = ua; spec = 1'b1;
    end else if (!o[0]) begin
      if (sa == -half && sb == -1) begin
        q = sa; r = 0; spec = 1'b1;
      end else begin
        q = sa / sb; r = sa % sb;
      end
    end else begin
      q = ua / ub; r = ua % ub;
    end
    v = o[1] ? r : q;
    return v[31:0] & m[31:0];
  endfunction

  function automatic string tag_of(input logic [1:0] o, input logic [31:0] x,
                                   input logic [31:0] y, input int w);
    logic [31:0] m;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    if ((y & m) == 0) return "R5";
    if (!o[0] && (x & m) == (32'd1 << (w - 1)) && (y & m) == m) return "R6";
    case (o)
      2'b01:   return "R1";
      2'b11:   return "R2";
      2'b00:   return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [31:0] res_of(input bit wide);
    return wide ? result_w : {{(32-WN){1'b0}}, result_n};
  endfunction

  task automatic run_op(input bit wide, input logic [1:0] o, input logic [31:0] x,
                        input logic [31:0] y, input bit poke, input bit hold);
    int n;
    int w;
    bit spec;
    logic [31:0] exp;
    logic [31:0] held;
    w   = wide ? WW : WN;
    exp = model(o, x, y, w, spec);
    @(negedge clk);
    op = o; a = x; b = y;
    if (wide) start_w = 1'b1; else start_n = 1'b1;
    @(negedge clk);
    n = 1;
    if (poke) begin
      // R8: a start while busy with different operands must be ignored
      op = ~o; a = ~x; b = x;
    end else begin
      start_w = 1'b0; start_n = 1'b0;
    end
    while (!(wide ? done_w : done_n) && n < 100) begin
      @(negedge clk);
      n++;
      start_w = 1'b0; start_n = 1'b0;
    end
    check(poke ? "R8" : tag_of(o, x, y, w), res_of(wide), exp);
    check("R7", n, spec ? 2 : w + 3);
    if (hold) begin
      held = res_of(wide);
      repeat (3) @(negedge clk);
      check("R9", {31'd0, wide ? done_w : done_n}, 32'd0);
      check("R9", res_of(wide), held);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", {30'd0, busy_n, done_n}, 32'd0);
    check("R10", {{(32-WN){1'b0}}, result_n}, 32'd0);
    check("R10", {30'd0, busy_w, done_w}, 32'd0);
    check("R10", result_w, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int o = 0; o < 4; o++)
      for (int x = 0; x < 32; x++)
        for (int y = 0; y < 32; y++)
          run_op(1'b0, 2'(o), 32'(x), 32'(y), (x == y), (x == 3 && y == 7));

    begin
      logic [31:0] corners [8];
      corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                  32'h7FFF_FFFF, 32'h2, 32'hFFFF_FFFE, 32'h0001_0003};
      for (int o = 0; o < 4; o++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            run_op(1'b1, 2'(o), corners[i], corners[j], (i == 4 && j == 5), (i == 3 && j == 2));
      for (int k = 0; k < 200; k++)
        run_op(1'b1, 2'(k), $urandom, (k % 3 == 0) ? ($urandom >> (k % 29)) : $urandom,
               (k % 50 == 0), (k % 40 == 1));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule